// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block controls a configurable set of general-purpose pins. The pins are split into two banks: a low bank holding pins `0 .. RESUME_BASE-1` and a high bank holding the rest. Each bank has its own group of byte-wide registers on a small byte-addressed bus with separate read and write strobes. Each pin has an enable bit, a direction bit and a level bit. When a pin is an enabled output, it drives its level onto the pad.

Pad inputs are synchronized by two flops. After that, each pin can detect a rising edge, a falling edge, or both. A detected edge sets a sticky status bit. Software clears that bit by writing 1 to it. Status bits that are unmasked by the per-pin interrupt enable are combined across both banks into one level interrupt. A separate per-pin routing register is plain read/write storage.

Top module: `twobank_gpio`

## Requirements
- R1: Address bit 5 selects the bank (0 low, 1 high). Bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rise-enable, 4 fall-enable, 5 interrupt-enable, 6 routing, 7 status. Bits 1:0 select the byte. A pin with in-bank index i sits in byte i/8 at bit i%8. Bits for pins that do not exist in a bank read as 0 and ignore writes.
- R2: After synchronous reset:
  - the enable bits equal the parameter `EN_RESET`;
  - every other register is 0;
  - `irq` is 0;
  - `pad_oe` equals `EN_RESET` (all pins start as outputs) and `pad_out` is 0.
- R3: Direction bit 1 makes a pin an input, with `pad_oe` low. Direction 0 on an enabled pin sets `pad_oe` high and drives the pin's level bit on `pad_out`.
- R4: A level write leaves the stored level of input pins unchanged. A level read returns the synchronized pad for inputs and the stored level for outputs.
- R5: A pin whose enable bit is 0 never raises `pad_oe` and never sets its status bit.
- R6: A rising edge on an enabled, rise-enabled pin sets its status bit. The same holds for falling edges on fall-enabled pins, and for either edge when both enables are set. The status bit reads as set after the third rising clock edge following the pad change, and not after the second.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clearing write, the bit stays set.
- R8: `irq` is high exactly while some status bit, in either bank, is set together with its interrupt-enable bit.
- R9: The routing register stores and returns written bits, with no other effect.
- R10: A pad change on an input pin appears in the level read after the second rising clock edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad drive values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets these corner cases:

- **Level write while an input.** The pin is switched back to output afterwards. A design that wrongly accepted the write would then show the new value on the pad instead of the value stored before.
- **Clear in the same cycle as an edge.** A clearing write is timed to land in the cycle a new edge is detected. A design where clear wins would lose that interrupt.
- **Latency.** Status and level reads are probed cycle by cycle. This exposes a missing or extra synchronizer stage.
- **Unused bit positions.** These are written with ones and must read back as zero.
- **Disabled pins.** A disabled pin with rise detection enabled must stay silent.
- **High-bank interrupt.** An edge in the high bank alone must raise the shared interrupt. A design that merged only one bank would miss it.

// File: rtl/twobank_gpio_pkg.sv
package twobank_gpio_pkg;

    localparam int LANES    = 4;
    localparam int BANK_MAX = LANES * 8;

    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_DIR    = 3'd1,
        RG_LEVEL  = 3'd2,
        RG_RISE   = 3'd3,
        RG_FALL   = 3'd4,
        RG_IRQEN  = 3'd5,
        RG_ROUTE  = 3'd6,
        RG_STATUS = 3'd7
    } gpio_reg_e;

    typedef struct packed {
        logic      bank;
        gpio_reg_e sel;
        logic [1:0] lane;
    } gpio_addr_t;

    typedef struct packed {
        logic       wr;
        gpio_reg_e  sel;
        logic [1:0] lane;
        logic [7:0] wdata;
    } bank_req_t;

    function automatic logic [BANK_MAX-1:0] lane_mask(input logic [1:0] lane);
        return {{(BANK_MAX-8){1'b0}}, 8'hFF} << {lane, 3'b000};
    endfunction

    function automatic logic [7:0] lane_pick(input logic [BANK_MAX-1:0] v,
                                             input logic [1:0] lane);
        return v[{lane, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/twobank_gpio_sync.sv
module twobank_gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/twobank_gpio_bank.sv
module twobank_gpio_bank
    import twobank_gpio_pkg::*;
#(
    parameter int               NPINS  = 8,
    parameter logic [NPINS-1:0] EN_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_req_t        req,
    input  logic [NPINS-1:0] pin_sync,
    output logic [7:0]       rd_byte,
    output logic [NPINS-1:0] drv_val,
    output logic [NPINS-1:0] drv_en,
    output logic             irq_any
);
    logic [NPINS-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, ie_q, route_q, sts_q, prev_q;
    logic [NPINS-1:0] wm, wv, clr, hit, sts_next, view;
    logic [BANK_MAX-1:0] lane_m, rep;

    assign lane_m = lane_mask(req.lane);
    assign rep    = {LANES{req.wdata}};
    assign wm     = lane_m[NPINS-1:0];
    assign wv     = rep[NPINS-1:0];

    function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old,
                                               input logic [NPINS-1:0] val,
                                               input logic [NPINS-1:0] msk);
        return (old & ~msk) | (val & msk);
    endfunction

    // Edge detection on the synchronized pad against its previous value.
    assign hit = en_q & ((rise_q & pin_sync & ~prev_q) |
                         (fall_q & ~pin_sync & prev_q));
    assign clr = (req.wr && req.sel == RG_STATUS) ? (wm & wv) : '0;
    // A newly detected edge outranks a same-cycle clear.
    assign sts_next = (sts_q & ~clr) | hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= EN_RST;
            dir_q   <= '0;
            lvl_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            ie_q    <= '0;
            route_q <= '0;
            sts_q   <= '0;
            prev_q  <= '0;
        end else begin
            prev_q <= pin_sync;
            sts_q  <= sts_next;
            if (req.wr) begin
                case (req.sel)
                    RG_ENABLE: en_q    <= merge(en_q, wv, wm);
                    RG_DIR:    dir_q   <= merge(dir_q, wv, wm);
                    RG_LEVEL:  lvl_q   <= merge(lvl_q, wv, wm & ~dir_q);
                    RG_RISE:   rise_q  <= merge(rise_q, wv, wm);
                    RG_FALL:   fall_q  <= merge(fall_q, wv, wm);
                    RG_IRQEN:  ie_q    <= merge(ie_q, wv, wm);
                    RG_ROUTE:  route_q <= merge(route_q, wv, wm);
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (req.sel)
            RG_ENABLE: view = en_q;
            RG_DIR:    view = dir_q;
            RG_LEVEL:  view = (dir_q & pin_sync) | (~dir_q & lvl_q);
            RG_RISE:   view = rise_q;
            RG_FALL:   view = fall_q;
            RG_IRQEN:  view = ie_q;
            RG_ROUTE:  view = route_q;
            RG_STATUS: view = sts_q;
            default:   view = '0;
        endcase
    end

    assign rd_byte = lane_pick(BANK_MAX'(view), req.lane);
    assign drv_en  = en_q & ~dir_q;
    assign drv_val = drv_en & lvl_q;
    assign irq_any = |(sts_q & ie_q);
endmodule

// File: rtl/twobank_gpio.sv
module twobank_gpio
    import twobank_gpio_pkg::*;
#(
    parameter int                  NUM_PINS    = 14,
    parameter int                  RESUME_BASE = 10,
    parameter logic [NUM_PINS-1:0] EN_RESET    = 14'h047F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [5:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_rd,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int LOW_N  = RESUME_BASE;
    localparam int HIGH_N = NUM_PINS - RESUME_BASE;

    gpio_addr_t          a;
    logic [NUM_PINS-1:0] pin_sync;
    logic [7:0]          bank_rd [2];
    logic [1:0]          bank_irq;

    assign a = gpio_addr_t'(bus_addr);

    twobank_gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int LO = (b == 0) ? 0 : RESUME_BASE;
        localparam int N  = (b == 0) ? LOW_N : HIGH_N;
        bank_req_t r;

        always_comb begin
            r.wr    = bus_wr && (a.bank == 1'(b));
            r.sel   = a.sel;
            r.lane  = a.lane;
            r.wdata = bus_wdata;
        end

        twobank_gpio_bank #(
            .NPINS  (N),
            .EN_RST (EN_RESET[LO +: N])
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .req      (r),
            .pin_sync (pin_sync[LO +: N]),
            .rd_byte  (bank_rd[b]),
            .drv_val  (pad_out[LO +: N]),
            .drv_en   (pad_oe[LO +: N]),
            .irq_any  (bank_irq[b])
        );
    end

    assign bus_rdata = bus_rd ? bank_rd[a.bank] : 8'h00;
    assign irq       = |bank_irq;
endmodule

// File: rtl/twobank_gpio_chk.sv
module twobank_gpio_chk #(
    parameter int NUM_PINS = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq
);
    // R2: the cycle right after reset has no pending interrupt
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R3: drive enables only move after a bus write
    a_r3_oe_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(pad_oe));

    // R4: driven values only move after a bus write
    a_r4_out_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(pad_out));

    // R7 / R8: a raised interrupt only drops through a bus write
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_wr) |=> irq);
endmodule

bind twobank_gpio twobank_gpio_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_wr  (bus_wr),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .irq     (irq)
);

// File: tb/test_twobank_gpio.sv
module test_twobank_gpio;
    localparam int NP = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    twobank_gpio i_twobank_gpio (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] addr, input logic [7:0] d);
        @(negedge clk);
        bus_addr = addr; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] addr, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = addr; bus_rd = 1'b1;
        #2;
        chk(req, 32'(bus_rdata), 32'(exp));
        bus_rd = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R2 low enable byte0", 6'h00, 8'h7F);
        rd_chk("R2 low enable byte1", 6'h01, 8'h00);
        rd_chk("R2 high enable", 6'h20, 8'h01);
        rd_chk("R2 direction", 6'h04, 8'h00);
        rd_chk("R2 status", 6'h1C, 8'h00);
        chk("R2 irq", 32'(irq), 32'd0);
        chk("R2 pad_oe", 32'(pad_oe), 32'h047F);
        chk("R2 pad_out", 32'(pad_out), 32'h0);
    endtask

    task automatic t_map;
        wr(6'h01, 8'hFF);
        rd_chk("R1 low byte1 unused bits", 6'h01, 8'h03);
        chk("R1 pad_oe after enable", 32'(pad_oe), 32'h077F);
        wr(6'h02, 8'hFF);
        rd_chk("R1 empty byte", 6'h02, 8'h00);
        wr(6'h24, 8'hFF);
        rd_chk("R1 high direction width", 6'h24, 8'h0F);
        chk("R3 high inputs undriven", 32'(pad_oe), 32'h037F);
        wr(6'h24, 8'h00);
        wr(6'h18, 8'hA5);
        rd_chk("R9 low routing", 6'h18, 8'hA5);
        wr(6'h38, 8'hFF);
        rd_chk("R9 high routing", 6'h38, 8'h0F);
        chk("R9 routing has no pad effect", 32'(pad_oe), 32'h077F);
    endtask

    task automatic t_level;
        wr(6'h08, 8'h55);
        chk("R3 driven level", 32'(pad_out[7:0]), 32'h55);
        rd_chk("R4 output readback", 6'h08, 8'h55);
        wr(6'h04, 8'h0F);
        chk("R3 inputs release pad", 32'(pad_oe[7:0]), 32'h70);
        @(negedge clk) pad_in[3:0] = 4'hA;
        wait_neg(2);
        rd_chk("R4 input readback", 6'h08, 8'h5A);
        wr(6'h08, 8'hFF);
        rd_chk("R4 mixed write", 6'h08, 8'hFA);
        @(negedge clk) pad_in[3:0] = 4'h0;
        wait_neg(2);
        rd_chk("R4 pad follow", 6'h08, 8'hF0);
        wr(6'h04, 8'h00);
        rd_chk("R4 input write ignored", 6'h08, 8'hF5);
        chk("R5 disabled pin not driven", 32'(pad_out[7:0]), 32'h75);
        // R10: two-stage synchronizer latency
        wr(6'h04, 8'h01);
        @(negedge clk) pad_in[0] = 1'b1;
        rd_chk("R10 one edge old value", 6'h08, 8'hF4);
        rd_chk("R10 two edges new value", 6'h08, 8'hF5);
        @(negedge clk) pad_in[0] = 1'b0;
        wr(6'h04, 8'h00);
    endtask

    task automatic t_edges;
        wr(6'h0C, 8'h14);
        wr(6'h10, 8'h18);
        @(negedge clk) pad_in[3:2] = 2'b11;
        rd_chk("R6 status after one", 6'h1C, 8'h00);
        rd_chk("R6 status after two", 6'h1C, 8'h00);
        rd_chk("R6 rising after three", 6'h1C, 8'h04);
        @(negedge clk) pad_in[3:2] = 2'b00;
        wait_neg(3);
        rd_chk("R6 falling", 6'h1C, 8'h0C);
        chk("R8 masked status", 32'(irq), 32'd0);
        wr(6'h1C, 8'h04);
        rd_chk("R7 partial clear", 6'h1C, 8'h08);
        wr(6'h1C, 8'hFF);
        rd_chk("R7 full clear", 6'h1C, 8'h00);
        @(negedge clk) pad_in[4] = 1'b1;
        wait_neg(3);
        rd_chk("R6 both-edge rise", 6'h1C, 8'h10);
        wr(6'h14, 8'h10);
        chk("R8 irq on", 32'(irq), 32'd1);
        // R7 race: falling edge detected in the clear cycle
        @(negedge clk) pad_in[4] = 1'b0;
        @(negedge clk);
        wr(6'h1C, 8'h10);
        rd_chk("R7 set wins over clear", 6'h1C, 8'h10);
        chk("R8 irq kept", 32'(irq), 32'd1);
        wr(6'h1C, 8'h10);
        rd_chk("R7 clear after race", 6'h1C, 8'h00);
        chk("R8 irq off", 32'(irq), 32'd0);
        wr(6'h14, 8'h00);
    endtask

    task automatic t_disabled;
        wr(6'h0C, 8'h80);
        @(negedge clk) pad_in[7] = 1'b1;
        wait_neg(3);
        rd_chk("R5 disabled no status", 6'h1C, 8'h00);
        chk("R5 disabled no drive", 32'(pad_oe[7]), 32'd0);
        @(negedge clk) pad_in[7] = 1'b0;
    endtask

    task automatic t_high_irq;
        wr(6'h2C, 8'h01);
        wr(6'h34, 8'h01);
        @(negedge clk) pad_in[10] = 1'b1;
        wait_neg(3);
        chk("R8 high bank irq", 32'(irq), 32'd1);
        rd_chk("R6 high status", 6'h3C, 8'h01);
        rd_chk("R1 low status untouched", 6'h1C, 8'h00);
        wr(6'h3C, 8'h01);
        chk("R8 high cleared", 32'(irq), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_level();
        t_edges();
        t_disabled();
        t_high_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule